// File: doc/BRIEF.md
# Latched Interrupt Status Aggregator

This block collects interrupt sources from peripherals into one latched status bit per source and drives one combined interrupt line to the CPU. A source sets its bit on a rising edge. The bit then stays set until firmware clears it. Firmware can also raise or drop any status bit itself. It does this through a write in which bit 0 chooses between set and clear.

Two read views share the same latched bits. The unmasked view shows every pending source. The masked view shows a source only when the CPU enable register lets it through. The enable bits do not map one-to-one onto status bits. A compile-time table gives each status bit an enable mask. A mask of zero means that bit is never gated. Several status bits can share one enable bit.

The CPU line is the OR of the masked view, registered once. Firmware typically reads the masked view and handles each set bit. It then clears that bit through either status offset.

Top module: `irq_status_agg`

## Requirements
- R1: The register bus has three word registers. Byte offset 0x0 is the unmasked status, 0x4 is the masked status and 0x8 is the CPU enable. Read data is registered: it appears on the clock edge after the address is presented and shows the state from before that edge. Any other offset reads zero.
- R2: The enable register at 0x8 is a plain 32-bit read/write register. A read returns the last value written.
- R3: A write to offset 0x0 or 0x4 with bit 0 = 1 sets every status bit in 31:1 that is written as 1. With bit 0 = 0, it clears every such bit instead. Bits written as 0 keep their value. Both offsets act on the same latched bits.
- R4: Bit 0 of both status registers always reads 0. A write whose only 1 is bit 0 changes nothing. Input srcIn[0] is ignored.
- R5: A rising edge on srcIn[i], for i from 1 to 31, sets status bit i. A source that stays high does not set its bit again after a clear. It must fall and rise again first.
- R6: A source rising edge in the same cycle as a software clear of that bit leaves the bit set.
- R7: A status bit appears in the masked view when its mask is zero or when any enable bit in its mask is 1. The unmasked view shows every latched bit whatever the enable register holds.
- R8: The default mask table is as follows. Status bits 1 to 15 each use enable bit i. Bits 16 to 23 are passed when enable bit 16 or enable bit 17 is set. Bits 24 to 31 are never gated.
- R9: irqOut is 1 exactly one clock after the masked view becomes nonzero. It is 0 exactly one clock after the masked view becomes zero.
- R10: A synchronous active-low reset clears status, enable, irqOut and read data to zero.
- R11: Clearing a bit through the unmasked offset also removes it from the masked view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 4 | Byte address of the register |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| srcIn | input | 32 | Interrupt sources, detected on rising edge (bit 0 unused) |
| irqOut | output | 1 | Combined CPU interrupt |

## Verification
The bench targets the same-cycle race between a source edge and a software clear. A design that let the clear win would lose an interrupt for good. It also holds a source high across a clear. Level-sensitive latching would fire again at once, and the bench reads the bit back as zero to catch that. The shared and zero masks of the default table are driven with the enable register set to single bits. An identity map, or one that gated the never-gated bits, shows the wrong masked word. The one-cycle lag of irqOut is sampled edge by edge on both rise and fall, and the set/clear selector is checked for turning into a stored status bit.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 4;

  typedef logic [REG_W-1:0] word_t;
  typedef word_t [REG_W-1:0] enMap_t;

  typedef enum logic [1:0] {
    RD_UMSK = 2'd0,
    RD_MSK  = 2'd1,
    RD_EN   = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  // Strobes from the bus decoder to the datapath.
  typedef struct packed {
    logic   stWr;   // write to either status offset
    logic   stSet;  // 1: set written ones, 0: clear them
    logic   enWr;   // write to enable register
    rdSel_e rdSel;  // register routed to read data
  } busStrobe_t;

  // Default mask table: 1..15 one-to-one, 16..23 share enables 16/17,
  // 24..31 ungated, bit 0 is the write selector and has no source.
  function automatic enMap_t defaultMap();
    enMap_t m;
    for (int i = 0; i < REG_W; i++) begin
      m[i] = '0;
      if (i >= 1 && i <= 15)       m[i][i] = 1'b1;
      else if (i >= 16 && i <= 23) m[i][17:16] = 2'b11;
    end
    return m;
  endfunction

endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic          selBit,
  output busStrobe_t    strobe
);

  localparam int WORD_AW = AW - 2;
  localparam logic [WORD_AW-1:0] OFF_UMSK = WORD_AW'(0);
  localparam logic [WORD_AW-1:0] OFF_MSK  = WORD_AW'(1);
  localparam logic [WORD_AW-1:0] OFF_EN   = WORD_AW'(2);

  logic [WORD_AW-1:0] wordAddr;
  logic hitUmsk, hitMsk, hitEn;

  assign wordAddr = busAddr[AW-1:2];
  assign hitUmsk  = (wordAddr == OFF_UMSK);
  assign hitMsk   = (wordAddr == OFF_MSK);
  assign hitEn    = (wordAddr == OFF_EN);

  always_comb begin
    strobe.stWr  = busWrEn && (hitUmsk || hitMsk);
    strobe.stSet = selBit;
    strobe.enWr  = busWrEn && hitEn;
    if (hitUmsk)     strobe.rdSel = RD_UMSK;
    else if (hitMsk) strobe.rdSel = RD_MSK;
    else if (hitEn)  strobe.rdSel = RD_EN;
    else             strobe.rdSel = RD_NONE;
  end

  // R1: a write never targets status and enable at once
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stWr, strobe.enWr}));

  // R1: an enable write strobe only comes from the enable offset
  p_en_decode_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enWr |-> (busWrEn && strobe.rdSel == RD_EN));

endmodule

// File: rtl/irqagg_datapath.sv
module irqagg_datapath
  import irqagg_pkg::*;
#(
  parameter int     W      = REG_W,
  parameter enMap_t EN_MAP = defaultMap()
) (
  input  logic       clk,
  input  logic       rstN,
  input  busStrobe_t strobe,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] srcIn,
  output logic [W-1:0] rdata,
  output logic       irqOut
);

  localparam logic [W-1:0] SEL_MASK = W'(1);

  logic [W-1:0] srcPrev, statusQ, enableQ, rdataQ;
  logic [W-1:0] srcEdge, swSet, swClr, statusD, gateVec, maskedView;
  logic         irqQ;

  assign srcEdge = srcIn & ~srcPrev & ~SEL_MASK;
  assign swSet   = (strobe.stWr &&  strobe.stSet) ? (wdata & ~SEL_MASK) : '0;
  assign swClr   = (strobe.stWr && !strobe.stSet) ? (wdata & ~SEL_MASK) : '0;
  // Source edges are applied after the clear, so they win a same-cycle race.
  assign statusD = ((statusQ & ~swClr) | swSet | srcEdge) & ~SEL_MASK;

  for (genvar g = 0; g < W; g++) begin : g_gate
    if (EN_MAP[g] == '0) begin : g_free
      assign gateVec[g] = 1'b1;
    end else begin : g_mapped
      assign gateVec[g] = |(EN_MAP[g] & enableQ);
    end
  end

  assign maskedView = statusQ & gateVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPrev <= '0;
      statusQ <= '0;
      enableQ <= '0;
      rdataQ  <= '0;
      irqQ    <= 1'b0;
    end else begin
      srcPrev <= srcIn;
      statusQ <= statusD;
      if (strobe.enWr) enableQ <= wdata;
      irqQ <= |maskedView;
      case (strobe.rdSel)
        RD_UMSK: rdataQ <= statusQ;
        RD_MSK:  rdataQ <= maskedView;
        RD_EN:   rdataQ <= enableQ;
        default: rdataQ <= '0;
      endcase
    end
  end

  assign rdata  = rdataQ;
  assign irqOut = irqQ;

  // R2: an enable write is stored as written
  p_en_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enWr |=> (enableQ == $past(wdata)));

  // R3: a clear with no competing edge leaves the cleared bits low
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stWr && !strobe.stSet && ((wdata & srcIn & ~srcPrev) == '0))
      |=> ((statusQ & $past(wdata) & ~SEL_MASK) == '0));

  // R4: a status read never shows the selector bit
  p_sel_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == RD_UMSK || strobe.rdSel == RD_MSK) |=> !rdata[0]);

  for (genvar s = 1; s < W; s++) begin : g_chk
    // R5, R6: a rising source edge always latches, even against a clear
    p_edge_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
      (srcIn[s] && !srcPrev[s]) |=> statusQ[s]);
  end

  // R9: an empty masked view drops the interrupt on the next edge
  p_irq_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskedView == '0) |=> !irqOut);

  // R9: a pending masked bit raises the interrupt on the next edge
  p_irq_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskedView != '0) |=> irqOut);

  // R10: reset leaves every register at zero
  p_reset_r10: assert property (@(posedge clk)
    !rstN |=> (statusQ == '0 && enableQ == '0 && !irqOut && rdata == '0));

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic [REG_W-1:0]  srcIn,
  output logic              irqOut
);

  busStrobe_t strobe;

  irqagg_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .selBit  (busWdata[0]),
    .strobe  (strobe)
  );

  irqagg_datapath #(.W(REG_W), .EN_MAP(defaultMap())) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wdata  (busWdata),
    .srcIn  (srcIn),
    .rdata  (busRdata),
    .irqOut (irqOut)
  );

endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;

  localparam logic [3:0] A_UMSK = 4'h0;
  localparam logic [3:0] A_MSK  = 4'h4;
  localparam logic [3:0] A_EN   = 4'h8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] srcIn = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_status_agg dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    @(posedge clk); #1;
    d = busRdata;
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(A_UMSK, v); check("R10 umsk after reset", v, 32'h0);
    busRead(A_MSK, v);  check("R10 msk after reset", v, 32'h0);
    busRead(A_EN, v);   check("R10 en after reset", v, 32'h0);
    check("R10 irq after reset", {31'h0, irqOut}, 32'h0);
    busRead(4'hC, v);   check("R1 unused offset", v, 32'h0);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    busWrite(A_EN, 32'hA5A5_5A5A);
    busRead(A_EN, v); check("R2 enable readback", v, 32'hA5A5_5A5A);
  endtask

  task automatic testSetClear();
    logic [31:0] v;
    busWrite(A_UMSK, 32'h0000_00F1);
    busRead(A_UMSK, v); check("R3 R4 set via umsk", v, 32'h0000_00F0);
    busRead(A_MSK, v);  check("R7 masked by enable", v, 32'h0000_0050);
    check("R9 irq with masked bits", {31'h0, irqOut}, 32'h1);
    busWrite(A_MSK, 32'h0000_0010);
    busRead(A_UMSK, v); check("R3 clear via msk offset", v, 32'h0000_00E0);
    busWrite(A_UMSK, 32'h0000_0040);
    busRead(A_MSK, v);  check("R11 umsk clear hides masked", v, 32'h0);
    busRead(A_UMSK, v); check("R11 other bits kept", v, 32'h0000_00A0);
    busWrite(A_UMSK, 32'hFFFF_FFFE);
    busRead(A_UMSK, v); check("R3 clear all", v, 32'h0);
  endtask

  task automatic testSelectorOnly();
    logic [31:0] v;
    busWrite(A_UMSK, 32'h0000_0001);
    @(negedge clk); srcIn[0] = 1'b1;
    @(negedge clk); srcIn[0] = 1'b0;
    busRead(A_UMSK, v); check("R4 selector only write and src0", v, 32'h0);
  endtask

  task automatic testMap();
    logic [31:0] v;
    busWrite(A_EN, 32'h0);
    busWrite(A_UMSK, 32'hFFFF_0001);
    busRead(A_UMSK, v); check("R7 unmasked shows all", v, 32'hFFFF_0000);
    busRead(A_MSK, v);  check("R8 ungated upper byte", v, 32'hFF00_0000);
    busWrite(A_EN, 32'h0002_0000);
    busRead(A_MSK, v);  check("R8 shared enable 17", v, 32'hFFFF_0000);
    busWrite(A_EN, 32'h0001_0000);
    busRead(A_MSK, v);  check("R8 shared enable 16", v, 32'hFFFF_0000);
    busWrite(A_EN, 32'h0000_0100);
    busRead(A_MSK, v);  check("R8 unrelated enable", v, 32'hFF00_0000);
    busWrite(A_UMSK, 32'hFFFF_FFFE);
    busWrite(A_EN, 32'h0);
  endtask

  task automatic testEdge();
    logic [31:0] v;
    @(negedge clk); srcIn[24] = 1'b1;
    busRead(A_UMSK, v); check("R5 edge latches", v, 32'h0100_0000);
    busWrite(A_UMSK, 32'h0100_0000);
    @(negedge clk);
    busRead(A_UMSK, v); check("R5 held level no relatch", v, 32'h0);
    @(negedge clk); srcIn[24] = 1'b0;
    @(negedge clk); srcIn[24] = 1'b1;
    busRead(A_UMSK, v); check("R5 second edge latches", v, 32'h0100_0000);
    busWrite(A_UMSK, 32'h0100_0000);
    @(negedge clk); srcIn[24] = 1'b0;
  endtask

  task automatic testRace();
    logic [31:0] v;
    @(negedge clk);
    srcIn[25] = 1'b1;
    busAddr = A_UMSK; busWdata = 32'h0200_0000; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
    busRead(A_UMSK, v); check("R6 edge beats clear", v, 32'h0200_0000);
    busWrite(A_UMSK, 32'h0200_0000);
    @(negedge clk); srcIn[25] = 1'b0;
    busRead(A_UMSK, v); check("R6 later clear works", v, 32'h0);
  endtask

  task automatic testIrqLag();
    busWrite(A_UMSK, 32'h8000_0001);
    check("R9 irq not yet high", {31'h0, irqOut}, 32'h0);
    @(posedge clk); #1;
    check("R9 irq high one cycle later", {31'h0, irqOut}, 32'h1);
    busWrite(A_UMSK, 32'h8000_0000);
    check("R9 irq not yet low", {31'h0, irqOut}, 32'h1);
    @(posedge clk); #1;
    check("R9 irq low one cycle later", {31'h0, irqOut}, 32'h0);
  endtask

  task automatic testResetMid();
    logic [31:0] v;
    busWrite(A_EN, 32'hFFFF_FFFF);
    busWrite(A_UMSK, 32'h0000_0003);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R10 irq cleared by reset", {31'h0, irqOut}, 32'h0);
    busRead(A_UMSK, v); check("R10 status cleared", v, 32'h0);
    busRead(A_EN, v);   check("R10 enable cleared", v, 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testEnable();
    testSetClear();
    testSelectorOnly();
    testMap();
    testEdge();
    testRace();
    testIrqLag();
    testResetMid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule